// File: doc/BRIEF.md
# Source and Sink Signal Sequencer

The block holds a pattern memory whose 16-bit words are split in two halves. The low byte of each word is a source pattern that is played out, one word per clock, onto eight timing-signal lines. The high byte receives the sink capture: a record of the eight live signal lines taken at the same address. Playback runs from address 0 up to and including a programmed end address. It then stops, or, when the wrap level is set, returns to address 0 and continues.

The two sides are started by rising edges on separate go inputs. The sink go starts the sink and the source together, so that capture and playback walk the same addresses. Each side has a level reset that holds it idle while asserted. Each output line has its own enable. A host port writes 16-bit words and reads them back. The memory is never cleared by reset. The depth is set by `ADDR_W`, which can be raised to 14 for a 16K-word store; the default is kept small.

Line order inside either byte, from bit 0 to bit 7: trigger, event-counter reset, bunch-counter reset, calibrate strobe, serial ID, serial trigger type, front-end reset, spare.

Top module: `pattern_seq`

## Requirements
- R1: A host write with `host_we_i` high stores `host_wdata_i` at `host_addr_i`. Bits 7:0 are the source byte and bits 15:8 are the sink byte. `host_rdata_o` presents the word at `host_addr_i` one clock edge after that address is applied.
- R2: A rising edge on `seq_go_i`, sampled at a clock edge, sets `src_busy_o` at that edge and starts playback at address 0. Holding `seq_go_i` high does not start another run; the input must drop and rise again.
- R3: After a start edge, the source byte of word j appears on `src_sig_o` from the (j+1)-th following clock edge.
- R4: When the wrap level `cyclic_i` is low, a run plays words 0 through `end_addr_i`, which is end+1 words. `src_busy_o` falls at the edge that presents the word at the end address. `src_sig_o` returns to zero at the next edge.
- R5: When `cyclic_i` is high, the word after the end address is word 0, and `src_busy_o` stays high.
- R6: Output line b is driven only while `src_en_i[b]` is 1. A disabled line stays low at all times.
- R7: A rising edge on `sink_go_i` starts both the sink and the source at address 0. At the (j+1)-th edge after the start, `live_sig_i` is written into the sink byte of word j. `sink_busy_o` follows the same end and wrap rules as the source.
- R8: While `seq_rst_i` is high, the source is idle: `src_busy_o` is low, `src_sig_o` is zero and go edges are ignored. The sink is not affected.
- R9: While `sink_rst_i` is high, the sink is idle and makes no captures; the sink bytes keep their contents. A sink go edge still starts the source.
- R10: A host write and a sink capture can hit the same word at the same edge. When they do, the sink byte takes the captured value and the source byte takes the host value.
- R11: Asserting `rst_ni` clears both busy flags and the output lines. Memory contents are kept across reset.
- R12: A go edge that arrives during a run restarts playback at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host word write strobe |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | 16 | Host write word, {sink, source} |
| host_rdata_o | output | 16 | Host read word, one edge latency |
| end_addr_i | input | ADDR_W | Last address of a run, inclusive |
| cyclic_i | input | 1 | Wrap to address 0 after the end address |
| src_en_i | input | 8 | Per-line output enables |
| seq_go_i | input | 1 | Source start, acts on its rising edge |
| seq_rst_i | input | 1 | Source hold-in-reset level |
| sink_go_i | input | 1 | Sink and source start, acts on its rising edge |
| sink_rst_i | input | 1 | Sink hold-in-reset level |
| live_sig_i | input | 8 | Live signal lines recorded by the sink |
| src_sig_o | output | 8 | Played timing-signal lines |
| src_busy_o | output | 1 | Source running |
| sink_busy_o | output | 1 | Sink running |

## Verification
A host write and a sink capture can fall on the same clock edge and target the same word. The bench starts a sink run with a four-word end address and raises the host write strobe for word 2 on exactly the edge at which the sink records word 2. It then reads the word back and expects the captured live value in the high byte and the host's value in the low byte. The neighbouring words must hold their own captures.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned SIG_W = 8;

  typedef logic [SIG_W-1:0] sig_t;

  typedef struct packed {
    sig_t snk;
    sig_t src;
  } word_t;
endpackage

// File: rtl/psq_edge.sv
module psq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/psq_ctr.sv
module psq_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic              cyclic_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              run_q;
  logic [ADDR_W-1:0] addr_q;
  logic              at_end;

  assign at_end = (addr_q == end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (hold_i) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      addr_q <= '0;
    end else if (run_q) begin
      if (at_end) begin
        run_q  <= cyclic_i;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign addr_o = addr_q;

  // R2 R12
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !hold_i |=> run_o && addr_o == '0);

  // R4
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !hold_i && !start_i && !cyclic_i && addr_o == end_i |=> !run_o);

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !hold_i && !start_i && cyclic_i && addr_o == end_i |=> run_o && addr_o == '0);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !run_o);
endmodule

// File: rtl/psq_mem.sv
module psq_mem
  import psq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              h_we_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  word_t             h_wdata_i,
  output word_t             h_rdata_o,
  input  logic [ADDR_W-1:0] play_addr_i,
  output sig_t              play_o,
  input  logic              cap_we_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  sig_t              cap_data_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  sig_t  src_q [DEPTH];
  sig_t  snk_q [DEPTH];
  word_t h_rdata_q;
  sig_t  play_q;
  logic  clash;

  // capture owns the sink byte when both target one word
  assign clash = cap_we_i && (cap_addr_i == h_addr_i);

  always_ff @(posedge clk_i) begin
    if (h_we_i)          src_q[h_addr_i]   <= h_wdata_i.src;
    if (h_we_i && !clash) snk_q[h_addr_i]  <= h_wdata_i.snk;
    if (cap_we_i)        snk_q[cap_addr_i] <= cap_data_i;
    h_rdata_q <= '{snk: snk_q[h_addr_i], src: src_q[h_addr_i]};
    play_q    <= src_q[play_addr_i];
  end

  assign h_rdata_o = h_rdata_q;
  assign play_o    = play_q;
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
  import psq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [15:0]       host_wdata_i,
  output logic [15:0]       host_rdata_o,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic              cyclic_i,
  input  logic [7:0]        src_en_i,
  input  logic              seq_go_i,
  input  logic              seq_rst_i,
  input  logic              sink_go_i,
  input  logic              sink_rst_i,
  input  logic [7:0]        live_sig_i,
  output logic [7:0]        src_sig_o,
  output logic              src_busy_o,
  output logic              sink_busy_o
);
  localparam int unsigned N_GO = 2;   // 0: source go, 1: sink go

  logic [N_GO-1:0]   go_lvl, go_rise;
  logic              src_start, snk_start;
  logic              src_run, snk_run;
  logic [ADDR_W-1:0] src_addr, snk_addr;
  logic              play_vld_q;
  logic              cap_we;
  sig_t              play_byte;
  word_t             rd_word;

  assign go_lvl = {sink_go_i, seq_go_i};

  for (genvar g = 0; g < N_GO; g++) begin : g_edge
    psq_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (go_lvl[g]),
      .rise_o(go_rise[g])
    );
  end

  assign src_start = go_rise[0] | go_rise[1];
  assign snk_start = go_rise[1];

  psq_ctr #(.ADDR_W(ADDR_W)) u_src_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (seq_rst_i),
    .start_i (src_start),
    .cyclic_i(cyclic_i),
    .end_i   (end_addr_i),
    .run_o   (src_run),
    .addr_o  (src_addr)
  );

  psq_ctr #(.ADDR_W(ADDR_W)) u_snk_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (sink_rst_i),
    .start_i (snk_start),
    .cyclic_i(cyclic_i),
    .end_i   (end_addr_i),
    .run_o   (snk_run),
    .addr_o  (snk_addr)
  );

  assign cap_we = snk_run & ~sink_rst_i;

  psq_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i      (clk_i),
    .h_we_i     (host_we_i),
    .h_addr_i   (host_addr_i),
    .h_wdata_i  (word_t'(host_wdata_i)),
    .h_rdata_o  (rd_word),
    .play_addr_i(src_addr),
    .play_o     (play_byte),
    .cap_we_i   (cap_we),
    .cap_addr_i (snk_addr),
    .cap_data_i (live_sig_i)
  );

  // read byte lands one edge after the address; valid flag tracks it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) play_vld_q <= 1'b0;
    else         play_vld_q <= src_run & ~seq_rst_i;
  end

  for (genvar b = 0; b < SIG_W; b++) begin : g_line
    assign src_sig_o[b] = play_vld_q & play_byte[b] & src_en_i[b];
  end

  assign host_rdata_o = rd_word;
  assign src_busy_o   = src_run;
  assign sink_busy_o  = snk_run;

  // R6
  line_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sig_o & ~src_en_i) == '0);

  // R8
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_i |=> !src_busy_o && src_sig_o == '0);

  // R7
  sink_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_start && !seq_rst_i && !sink_rst_i |=> src_busy_o && sink_busy_o && src_addr == snk_addr);

  // R9
  sink_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_rst_i |=> !sink_busy_o);
endmodule

// File: tb/pattern_seq_tb.sv
module pattern_seq_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [15:0]   host_wdata_i = '0;
  logic [15:0]   host_rdata_o;
  logic [AW-1:0] end_addr_i = AW'(3);
  logic          cyclic_i = 1'b0;
  logic [7:0]    src_en_i = 8'hFF;
  logic          seq_go_i = 1'b0, seq_rst_i = 1'b0;
  logic          sink_go_i = 1'b0, sink_rst_i = 1'b0;
  logic [7:0]    live_sig_i = '0;
  logic [7:0]    src_sig_o;
  logic          src_busy_o, sink_busy_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_src [8];
  logic [7:0] exp_snk [8];

  always #5 clk = ~clk;

  pattern_seq #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .end_addr_i(end_addr_i), .cyclic_i(cyclic_i), .src_en_i(src_en_i),
    .seq_go_i(seq_go_i), .seq_rst_i(seq_rst_i),
    .sink_go_i(sink_go_i), .sink_rst_i(sink_rst_i),
    .live_sig_i(live_sig_i), .src_sig_o(src_sig_o),
    .src_busy_o(src_busy_o), .sink_busy_o(sink_busy_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [15:0] d);
    host_addr_i = AW'(a); host_wdata_i = d; host_we_i = 1'b1;
    tick();
    host_we_i = 1'b0;
    exp_src[a] = d[7:0]; exp_snk[a] = d[15:8];
  endtask

  task automatic rd_chk(string tag, int a);
    host_addr_i = AW'(a);
    tick();
    chk(tag, host_rdata_o, {exp_snk[a], exp_src[a]});
  endtask

  function automatic logic [7:0] pat(int i);
    case (i)
      0: return 8'h81; 1: return 8'h42; 2: return 8'h24; 3: return 8'h18;
      4: return 8'h99; 5: return 8'h66; 6: return 8'hC3; default: return 8'h3C;
    endcase
  endfunction

  task automatic t_reset();
    chk("R11 src_busy after reset", 16'(src_busy_o), 16'h0);
    chk("R11 sink_busy after reset", 16'(sink_busy_o), 16'h0);
    chk("R11 lines after reset", 16'(src_sig_o), 16'h0);
  endtask

  task automatic t_rw();
    for (int i = 0; i < 8; i++) wr(i, {(i == 5) ? 8'hA5 : 8'h00, pat(i)});
    for (int i = 0; i < 8; i++) rd_chk("R1 readback", i);
  endtask

  task automatic t_play();
    seq_go_i = 1'b1;
    tick();
    chk("R2 busy at start", 16'(src_busy_o), 16'h1);
    chk("R2 lines before first word", 16'(src_sig_o), 16'h0);
    for (int j = 0; j < 4; j++) begin
      tick();
      chk("R3 played word", 16'(src_sig_o), 16'(exp_src[j]));
      chk("R4 busy during run", 16'(src_busy_o), 16'(j < 3));
    end
    tick();
    chk("R4 lines after last word", 16'(src_sig_o), 16'h0);
    tick(); tick();
    chk("R2 held go no restart", 16'(src_busy_o), 16'h0);
    seq_go_i = 1'b0;
    tick();
  endtask

  task automatic t_cyclic_hold();
    cyclic_i = 1'b1;
    seq_go_i = 1'b1; tick(); seq_go_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick();
      chk("R5 wrapped word", 16'(src_sig_o), 16'(exp_src[k % 4]));
      chk("R5 busy stays", 16'(src_busy_o), 16'h1);
    end
    seq_rst_i = 1'b1;
    tick();
    chk("R8 busy in hold", 16'(src_busy_o), 16'h0);
    chk("R8 lines in hold", 16'(src_sig_o), 16'h0);
    seq_go_i = 1'b1; tick(); seq_go_i = 1'b0; tick();
    chk("R8 go ignored in hold", 16'(src_busy_o), 16'h0);
    seq_rst_i = 1'b0; cyclic_i = 1'b0;
    tick();
    chk("R8 idle after hold", 16'(src_busy_o), 16'h0);
  endtask

  task automatic t_enable();
    src_en_i = 8'h05;
    seq_go_i = 1'b1; tick(); seq_go_i = 1'b0;
    for (int j = 0; j < 4; j++) begin
      tick();
      chk("R6 gated lines", 16'(src_sig_o), 16'(exp_src[j] & 8'h05));
    end
    tick();
    src_en_i = 8'hFF;
  endtask

  task automatic t_sink();
    sink_go_i = 1'b1; tick(); sink_go_i = 1'b0;
    chk("R7 sink busy at start", 16'(sink_busy_o), 16'h1);
    chk("R7 source started too", 16'(src_busy_o), 16'h1);
    for (int j = 0; j < 4; j++) begin
      live_sig_i = 8'hA0 + 8'(j);
      tick();
      exp_snk[j] = 8'hA0 + 8'(j);
      chk("R7 source plays in sink run", 16'(src_sig_o), 16'(exp_src[j]));
      chk("R7 sink busy", 16'(sink_busy_o), 16'(j < 3));
    end
    tick();
    for (int j = 0; j < 5; j++) rd_chk("R7 captured word", j);
  endtask

  task automatic t_sink_hold();
    sink_rst_i = 1'b1;
    sink_go_i = 1'b1; tick(); sink_go_i = 1'b0;
    chk("R9 sink held", 16'(sink_busy_o), 16'h0);
    chk("R9 source still starts", 16'(src_busy_o), 16'h1);
    live_sig_i = 8'h55;
    repeat (5) tick();
    sink_rst_i = 1'b0;
    tick();
    for (int j = 0; j < 4; j++) rd_chk("R9 sink bytes kept", j);
  endtask

  task automatic t_collide();
    sink_go_i = 1'b1; tick(); sink_go_i = 1'b0;
    for (int j = 0; j < 4; j++) begin
      live_sig_i = 8'hC0 + 8'(j);
      if (j == 2) begin
        host_we_i = 1'b1; host_addr_i = AW'(2); host_wdata_i = 16'h5A77;
      end
      tick();
      host_we_i = 1'b0;
      exp_snk[j] = 8'hC0 + 8'(j);
    end
    exp_src[2] = 8'h77;
    tick();
    for (int j = 1; j < 4; j++) rd_chk("R10 clash word", j);
  endtask

  task automatic t_restart();
    seq_go_i = 1'b1; tick(); tick();
    seq_go_i = 1'b0; tick();
    seq_go_i = 1'b1; tick();
    chk("R12 word before restart", 16'(src_sig_o), 16'(exp_src[2]));
    tick();
    chk("R12 restarted at zero", 16'(src_sig_o), 16'(exp_src[0]));
    chk("R12 busy after restart", 16'(src_busy_o), 16'h1);
    tick(); tick(); tick();
    chk("R12 run ends after restart", 16'(src_busy_o), 16'h0);
    chk("R12 last word", 16'(src_sig_o), 16'(exp_src[3]));
    seq_go_i = 1'b0;
    tick(); tick();
  endtask

  task automatic t_keep();
    seq_go_i = 1'b1; sink_go_i = 1'b1; tick();
    seq_go_i = 1'b0; sink_go_i = 1'b0;
    rst_ni = 1'b0;
    tick();
    chk("R11 busy cleared", 16'({src_busy_o, sink_busy_o}), 16'h0);
    chk("R11 lines cleared", 16'(src_sig_o), 16'h0);
    rst_ni = 1'b1;
    tick();
    for (int j = 0; j < 6; j++) rd_chk("R11 memory kept", j);
  endtask

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_rw();
    t_play();
    t_cyclic_hold();
    t_enable();
    t_sink();
    t_sink_hold();
    t_collide();
    t_restart();
    t_keep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule